// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block decides whether an I2C transfer is addressed to this device. The byte that follows a START or repeated START comes in already deserialised. The block compares it with a programmable own-address value. The upper seven bits of that value are the device address. Its least significant bit enables the general-call match on the all-zero byte.

When the byte matches, the block sets one of two status flags, one per match type. It also reports the transfer direction and raises an interrupt request, which the host clears with a one-cycle strobe.

Bytes arrive on a valid/ready stream. Each byte carries a side flag that marks it as the first byte after a START. The block never applies back-pressure: `byte_ready_o` is high whenever reset is released. A byte is consumed in any cycle where `byte_valid_i` is high. Only consumed bytes that carry the first-byte flag are evaluated. Consumed data bytes are dropped without effect.

The flags and the interrupt are registered. They change on the clock edge that consumes the byte, and the host sees them from the next cycle on.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, `own_hit_o`, `gc_hit_o`, `dir_rd_o` and `irq_o` are 0, and `byte_ready_o` is 1.
- R2: A consumed first byte whose bits [7:1] equal `own_addr_i[7:1]` sets `own_hit_o` on the next cycle, whatever the value of byte bit 0.
- R3: `dir_rd_o` is loaded with bit 0 of a first byte that makes an own-address match (1 = slave transmits, 0 = slave receives). It is 0 whenever `own_hit_o` is 0.
- R4: A consumed first byte of 00h sets `gc_hit_o` only when `own_addr_i[0]` (the general-call enable) is 1. With the enable at 0, 00h gives no general-call match.
- R5: A first byte of 01h never sets `gc_hit_o`.
- R6: When the own-address match and the general-call match both hold (own address 0 with the enable set), only `own_hit_o` is set.
- R7: A consumed byte with `byte_first_i` = 0, or any cycle with `byte_valid_i` = 0, leaves all three status outputs unchanged. The exception is `start_i`.
- R8: Any match sets `irq_o`. It stays high until a cycle with `irq_clr_i` = 1 that has no new match. A new match in the same cycle as the clear wins.
- R9: `start_i` clears `own_hit_o`, `gc_hit_o` and `dir_rd_o` on the next cycle and leaves `irq_o` alone. A first byte consumed in the same cycle overrides the clear.
- R10: A consumed first byte that matches nothing loads all three status outputs with 0 and does not set `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse on START or repeated START |
| byte_valid_i | input | 1 | Received byte present |
| byte_ready_o | output | 1 | Block can take a byte (always 1 out of reset) |
| byte_data_i | input | 8 | Received byte, MSB first on the wire |
| byte_first_i | input | 1 | Byte is the first after START |
| own_addr_i | input | 8 | [7:1] own address, [0] general-call enable |
| irq_clr_i | input | 1 | One-cycle interrupt clear |
| irq_o | output | 1 | Interrupt request |
| own_hit_o | output | 1 | Own-address match flag |
| gc_hit_o | output | 1 | General-call match flag |
| dir_rd_o | output | 1 | Direction of the own-address match (1 = read) |

## Verification
The assertions assume that `own_addr_i` only changes at clock edges. They also assume that every input is a known 0 or 1 after reset. The irq assertions place no limit on how often clears arrive. The stimulus drives every input half a cycle away from the sampling edge and never leaves a pin undriven. It holds the own address for a burst of cycles and then changes it. It biases the first bytes toward the own address, 00h and 01h, so that all match combinations, including the overlap case, happen often.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  // outcome of comparing one first byte
  typedef struct packed {
    logic own;
    logic gc;
    logic rd;
  } am_result_t;

  localparam am_result_t AM_NONE = '{own: 1'b0, gc: 1'b0, rd: 1'b0};
endpackage

// File: rtl/am_compare.sv
module am_compare
  import i2c_am_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W:0] rx_byte,
  input  logic [ADDR_W:0] own_reg,
  output am_result_t      result,
  output logic            any_hit
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam logic [BYTE_W-1:0] GC_CODE = '0;

  logic own_eq;
  logic gc_eq;
  logic gc_en;

  assign gc_en  = own_reg[0];
  assign own_eq = (rx_byte[BYTE_W-1:1] == own_reg[BYTE_W-1:1]);
  // the full byte is compared, so 01h can never be a general call
  assign gc_eq  = gc_en && (rx_byte == GC_CODE);

  always_comb begin
    result = AM_NONE;
    if (own_eq) begin
      result.own = 1'b1;
      result.rd  = rx_byte[0];
    end else if (gc_eq) begin
      result.gc  = 1'b1;
    end
  end

  assign any_hit = result.own || result.gc;

  // R5
  rx_01_never_gc_chk: assert final (!(rx_byte == BYTE_W'(1) && result.gc));
endmodule

// File: rtl/am_status_reg.sv
module am_status_reg
  import i2c_am_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       eval,
  input  logic       start,
  input  am_result_t nxt,
  output am_result_t cur
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= AM_NONE;
    end else if (eval) begin
      cur <= nxt;
    end else if (start) begin
      cur <= AM_NONE;
    end
  end

  // R6
  one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cur.own, cur.gc}) <= 1);

  // R3
  dir_needs_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur.rd |-> cur.own);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eval && !start) |=> $stable(cur));

  // R9
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !eval) |=> (cur == AM_NONE));
endmodule

// File: rtl/am_irq_ctrl.sv
module am_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else if (set_req) begin
      irq <= 1'b1;
    end else if (clr_req) begin
      irq <= 1'b0;
    end
  end

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_req) |=> irq);

  // R8
  irq_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> irq);

  // R10
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !set_req) |=> !irq);
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              byte_valid_i,
  output logic              byte_ready_o,
  input  logic [ADDR_W:0]   byte_data_i,
  input  logic              byte_first_i,
  input  logic [ADDR_W:0]   own_addr_i,
  input  logic              irq_clr_i,
  output logic              irq_o,
  output logic              own_hit_o,
  output logic              gc_hit_o,
  output logic              dir_rd_o
);
  am_result_t cmp_res;
  am_result_t stat;
  logic       cmp_hit;
  logic       eval;

  // the block never stalls the byte stream
  assign byte_ready_o = rst_n;
  assign eval = byte_valid_i && byte_ready_o && byte_first_i;

  am_compare #(.ADDR_W(ADDR_W)) u_cmp (
    .rx_byte (byte_data_i),
    .own_reg (own_addr_i),
    .result  (cmp_res),
    .any_hit (cmp_hit)
  );

  am_status_reg u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .eval  (eval),
    .start (start_i),
    .nxt   (cmp_res),
    .cur   (stat)
  );

  am_irq_ctrl u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (eval && cmp_hit),
    .clr_req (irq_clr_i),
    .irq     (irq_o)
  );

  assign own_hit_o = stat.own;
  assign gc_hit_o  = stat.gc;
  assign dir_rd_o  = stat.rd;

  // R2
  own_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && byte_data_i[ADDR_W:1] == own_addr_i[ADDR_W:1]) |=> own_hit_o);

  // R4
  gc_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !own_addr_i[0]) |=> !gc_hit_o);

  // R7
  data_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid_i && !byte_first_i && !start_i)
      |=> $stable({own_hit_o, gc_hit_o, dir_rd_o}));
endmodule

// File: tb/i2c_addr_match_tb.sv
module i2c_addr_match_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, byte_valid_i = 1'b0, byte_first_i = 1'b0, irq_clr_i = 1'b0;
  logic [7:0] byte_data_i = 8'h00, own_addr_i = 8'h00;
  logic byte_ready_o, irq_o, own_hit_o, gc_hit_o, dir_rd_o;

  int n_chk = 0;
  int n_bad = 0;
  logic e_own = 0, e_gc = 0, e_rd = 0, e_irq = 0;

  always #2 clk = ~clk;

  i2c_addr_match dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_valid_i(byte_valid_i),
    .byte_ready_o(byte_ready_o), .byte_data_i(byte_data_i),
    .byte_first_i(byte_first_i), .own_addr_i(own_addr_i),
    .irq_clr_i(irq_clr_i), .irq_o(irq_o), .own_hit_o(own_hit_o),
    .gc_hit_o(gc_hit_o), .dir_rd_o(dir_rd_o)
  );

  function automatic logic [2:0] predict(input logic [7:0] b, input logic [7:0] a);
    // {own, gc, rd}
    if (b[7:1] == a[7:1]) return {1'b1, 1'b0, b[0]};
    if (a[0] && b == 8'h00) return 3'b010;
    return 3'b000;
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%b exp=%b (irq,own,gc,rd) t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input string req, input logic s, input logic v, input logic f,
                      input logic [7:0] b, input logic [7:0] a, input logic c);
    logic [2:0] p;
    start_i = s; byte_valid_i = v; byte_first_i = f; byte_data_i = b;
    own_addr_i = a; irq_clr_i = c;
    @(posedge clk);
    p = predict(b, a);
    if (v && f) begin
      {e_own, e_gc, e_rd} = p;
      if (p[2] || p[1]) e_irq = 1'b1;
      else if (c) e_irq = 1'b0;
    end else begin
      if (s) {e_own, e_gc, e_rd} = 3'b000;
      if (c) e_irq = 1'b0;
    end
    @(negedge clk);
    check(req, {irq_o, own_hit_o, gc_hit_o, dir_rd_o}, {e_irq, e_own, e_gc, e_rd});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4417));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {irq_o, own_hit_o, gc_hit_o, dir_rd_o}, 4'b0000);
    n_chk++;
    if (byte_ready_o !== 1'b0) begin n_bad++; $display("FAIL R1 ready act=%b exp=0 in reset", byte_ready_o); end
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (byte_ready_o !== 1'b1) begin n_bad++; $display("FAIL R1 ready act=%b exp=1", byte_ready_o); end
    check("R1", {irq_o, own_hit_o, gc_hit_o, dir_rd_o}, 4'b0000);

    // directed corner cases
    step("R2", 1, 1, 1, 8'hA4, 8'hA5, 0);  // own write, direction 0
    step("R3", 0, 1, 1, 8'hA5, 8'hA4, 0);  // own read
    step("R8", 0, 0, 0, 8'h00, 8'hA4, 1);  // clear irq
    step("R7", 0, 1, 0, 8'h12, 8'hA4, 0);  // data byte ignored
    step("R9", 1, 0, 0, 8'h00, 8'hA4, 0);  // start clears flags
    step("R4", 0, 1, 1, 8'h00, 8'h31, 1);  // gc enabled, set beats clear
    step("R9", 1, 1, 1, 8'h00, 8'h31, 0);  // byte wins over start
    step("R4", 0, 1, 1, 8'h00, 8'h30, 1);  // gc disabled
    step("R5", 0, 1, 1, 8'h01, 8'h31, 0);
    step("R6", 0, 1, 1, 8'h00, 8'h01, 1);  // own address 0 plus enable
    step("R10", 0, 1, 1, 8'h7E, 8'h31, 1); // no match clears flags, irq cleared
    step("R7", 0, 0, 1, 8'h30, 8'h31, 0);  // valid low: nothing

    // constrained random
    for (int blk = 0; blk < 400; blk++) begin
      logic [7:0] a;
      a = 8'($urandom);
      if ($urandom % 6 == 0) a[7:1] = 7'h00;
      for (int k = 0; k < 20; k++) begin
        logic [7:0] b;
        int sel;
        sel = $urandom % 8;
        case (sel)
          0, 1: b = {a[7:1], 1'($urandom)};
          2:    b = 8'h00;
          3:    b = 8'h01;
          default: b = 8'($urandom);
        endcase
        step("R2-R10 random", ($urandom % 5) == 0, ($urandom % 4) != 0,
             ($urandom % 2) == 0, b, a, ($urandom % 4) == 0);
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule